// File: doc/BRIEF.md
# Tuner Status Read Port (two-wire slave)

This block is a two-wire serial slave that lets a host controller poll a small status word. The open-drain clock and data lines are sampled with a fast system clock. The block detects bus START and STOP conditions and checks the incoming address against a fixed five-bit prefix plus two bits taken from board-level select inputs. On a matching read it returns a status byte. That byte combines a sticky power-on indicator, the loop-lock indication, the gain-control indication and a three-bit converter code.

The status fields are latched at the start of every byte, so each byte is internally coherent. The slave keeps sending fresh status bytes for as long as the host acknowledges them. When the host withholds its acknowledge, the slave lets go of the data line and clears the power-on indicator. A matching write is acknowledged for its address only and changes nothing. The data-line output is an enable that pulls the line low.

Top module: `statusReadPort`

## Requirements
- R1: After reset the data-line pull-down is off and the power-on indicator reads as 1 in the first status byte returned.
- R2: A START (data falls while clock is high) restarts address reception at any point, including in the middle of a byte. A STOP (data rises while clock is high) returns the slave to idle with the data line released.
- R3: An address byte, MSB first, of 1,1,0,0,0,S1,S0,D, where S1 and S0 equal the select inputs, is acknowledged by pulling the data line low during the ninth clock.
- R4: A non-matching address gets no acknowledge, and the slave keeps the data line released until the next START.
- R5: A matching write (D=0) has its address acknowledged. The data bytes that follow get no acknowledge and have no effect on any status field.
- R6: A matching read (D=1) returns, MSB first: power-on indicator, lock flag, 1, 1, gain flag, code bit 2, code bit 1, code bit 0.
- R7: While the host acknowledges (data low in the ninth clock), another status byte follows. It is built from the status inputs present when that byte begins.
- R8: A host non-acknowledge after a status byte releases the data line and clears the power-on indicator. Every later status byte carries 0 in that position.
- R9: The power-on indicator is not cleared by a write, or by an address phase that is aborted or does not match.
- R10: The slave changes the data-line drive only while the clock line is low, so the data line is stable during every clock-high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low asynchronous reset (power-on) |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| selBits | input | 2 | Board-selected low address bits (S1,S0) |
| lockFlag | input | 1 | Loop locked indication |
| agcFlag | input | 1 | Gain-control take-over reached |
| convCode | input | 3 | Converter output code |

## Verification
The bench builds the block with its default parameters: a two-stage line synchronizer, an eight-bit byte, two select bits and a three-bit code. With those values, the prefix and the select-bit matching can be hit and missed on purpose. Multi-byte reads cross the eight-bit counter boundary several times, and the status inputs can be changed during the host acknowledge so that per-byte recapture is visible. A bench bit phase of twelve system clocks leaves room for the synchronizer delay, so a data change in the clock-high phase would show up as a difference between two samples taken in that phase.

// File: rtl/statusRdPkg.sv
package statusRdPkg;
  typedef enum logic [1:0] {DRV_REL, DRV_ACK, DRV_DATA} drvModeT;

  typedef struct packed {
    logic    clrCnt;
    logic    capRx;
    logic    loadTx;
    logic    shiftTx;
    logic    capMack;
    logic    clrPor;
    drvModeT drv;
  } ctrlStrobeT;
endpackage

// File: rtl/statusRdDatapath.sv
module statusRdDatapath
  import statusRdPkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int BYTE_W     = 8,
  parameter int SEL_W      = 2,
  parameter int CODE_W     = 3,
  parameter logic [BYTE_W-SEL_W-2:0] FIXED_ADDR = 5'b11000,
  localparam int CNT_W     = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [SEL_W-1:0]  selBits,
  input  logic              lockFlag,
  input  logic              agcFlag,
  input  logic [CODE_W-1:0] convCode,
  input  ctrlStrobeT        ctrl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              addrMatch,
  output logic              isRead,
  output logic              mackAck,
  output logic              sdaPullLow
);
  logic [SYNC_DEPTH-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] rxReg, txReg, statusWord;
  logic porFlag;

  for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe[i] <= 1'b1;
          sdaPipe[i] <= 1'b1;
        end else begin
          sclPipe[i] <= sclPipe[i-1];
          sdaPipe[i] <= sdaPipe[i-1];
        end
    end
  end

  assign sclS = sclPipe[SYNC_DEPTH-1];
  assign sdaS = sdaPipe[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign statusWord = {porFlag, lockFlag, 2'b11, agcFlag, convCode};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '1;
      bitCnt  <= '0;
      porFlag <= 1'b1;
      mackAck <= 1'b0;
    end else begin
      if (ctrl.capRx)   rxReg <= {rxReg[BYTE_W-2:0], sdaS};
      if (ctrl.loadTx)  txReg <= statusWord;
      else if (ctrl.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b1};
      if (ctrl.clrCnt)  bitCnt <= '0;
      else if (ctrl.capRx || ctrl.shiftTx) bitCnt <= bitCnt + 1'b1;
      if (ctrl.clrPor)  porFlag <= 1'b0;
      if (ctrl.capMack) mackAck <= ~sdaS;
    end

  assign addrMatch = (rxReg[BYTE_W-1:SEL_W+1] == FIXED_ADDR) && (rxReg[SEL_W:1] == selBits);
  assign isRead    = rxReg[0];
  assign sdaPullLow = (ctrl.drv == DRV_ACK) || ((ctrl.drv == DRV_DATA) && !txReg[BYTE_W-1]);
endmodule

// File: rtl/statusRdControl.sv
module statusRdControl
  import statusRdPkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             addrMatch,
  input  logic             isRead,
  input  logic             mackAck,
  output ctrlStrobeT       ctrl
);
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_AACK, ST_TX, ST_MACK, ST_SKIP} stateT;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  stateT state, nextState;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;

  always_comb begin
    ctrl      = '0;
    ctrl.drv  = DRV_REL;
    nextState = state;
    if (stopEv) begin
      nextState   = ST_IDLE;
      ctrl.clrCnt = 1'b1;
    end else if (startEv) begin
      nextState   = ST_ADDR;
      ctrl.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt != FULL) ctrl.capRx = 1'b1;
          if (sclFall && bitCnt == FULL) begin
            ctrl.clrCnt = 1'b1;
            nextState   = addrMatch ? ST_AACK : ST_SKIP;
          end
        end
        ST_AACK: begin
          ctrl.drv = DRV_ACK;
          if (sclFall) begin
            if (isRead) begin
              ctrl.loadTx = 1'b1;
              nextState   = ST_TX;
            end else begin
              nextState   = ST_SKIP;
            end
          end
        end
        ST_TX: begin
          ctrl.drv = DRV_DATA;
          if (sclFall) begin
            if (bitCnt == LAST) begin
              ctrl.clrCnt = 1'b1;
              nextState   = ST_MACK;
            end else begin
              ctrl.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) ctrl.capMack = 1'b1;
          if (sclFall) begin
            if (mackAck) begin
              ctrl.loadTx = 1'b1;
              nextState   = ST_TX;
            end else begin
              ctrl.clrPor = 1'b1;
              nextState   = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/statusReadPort.sv
module statusReadPort
  import statusRdPkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int BYTE_W     = 8,
  parameter int SEL_W      = 2,
  parameter int CODE_W     = 3,
  parameter logic [BYTE_W-SEL_W-2:0] FIXED_ADDR = 5'b11000,
  localparam int CNT_W     = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic [SEL_W-1:0]  selBits,
  input  logic              lockFlag,
  input  logic              agcFlag,
  input  logic [CODE_W-1:0] convCode
);
  ctrlStrobeT       ctrl;
  logic             sclRise, sclFall, startEv, stopEv;
  logic             addrMatch, isRead, mackAck;
  logic [CNT_W-1:0] bitCnt;

  statusRdDatapath #(
    .SYNC_DEPTH(SYNC_DEPTH), .BYTE_W(BYTE_W), .SEL_W(SEL_W),
    .CODE_W(CODE_W), .FIXED_ADDR(FIXED_ADDR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .selBits(selBits), .lockFlag(lockFlag), .agcFlag(agcFlag),
    .convCode(convCode), .ctrl(ctrl),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .bitCnt(bitCnt), .addrMatch(addrMatch), .isRead(isRead),
    .mackAck(mackAck), .sdaPullLow(sdaPullLow)
  );

  statusRdControl #(.BYTE_W(BYTE_W)) i_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .bitCnt(bitCnt),
    .addrMatch(addrMatch), .isRead(isRead), .mackAck(mackAck), .ctrl(ctrl)
  );
endmodule

// File: rtl/statusRdChecker.sv
module statusRdChecker
  import statusRdPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sdaPullLow,
  input logic       sclFall,
  input logic       stopEv,
  input logic       addrMatch,
  input logic       isRead,
  input ctrlStrobeT ctrl
);
  // R10: drive only changes right after a clock fall was seen
  a_r10_change_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> $past(sclFall));

  // R4: released modes never pull the line
  a_r4_released_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.drv == DRV_REL) |-> !sdaPullLow);

  // R2: a STOP leaves the line released on the next cycle
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (ctrl.drv == DRV_REL) && !sdaPullLow);

  // R3: an acknowledge begins only with a matching address
  a_r3_ack_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl.drv == DRV_ACK) |-> addrMatch);

  // R8, R9: the power-on indicator is cleared only within a read
  a_r8_clear_in_read: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrPor |-> isRead && addrMatch);
endmodule

bind statusReadPort statusRdChecker i_chk (
  .clk(clk), .rstN(rstN), .sdaPullLow(sdaPullLow), .sclFall(sclFall),
  .stopEv(stopEv), .addrMatch(addrMatch), .isRead(isRead), .ctrl(ctrl)
);

// File: tb/test_statusReadPort.sv
module test_statusReadPort;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sdaM = 1'b1;
  logic sdaLine, pullLow;
  logic [1:0] sel = 2'b00;
  logic lockF = 1'b0, agcF = 1'b0;
  logic [2:0] code = 3'b000;
  int nChk = 0, nBad = 0;
  bit expPor = 1'b1;

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~pullLow;

  statusReadPort i_statusReadPort (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaPullLow(pullLow), .selBits(sel), .lockFlag(lockF),
    .agcFlag(agcF), .convCode(code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus(bit por, logic lk, logic ag, logic [2:0] cd);
    return {por, lk, 2'b11, ag, cd};
  endfunction

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic startC;
    sdaM = 1'b1; wq; scl = 1'b1; wq; sdaM = 1'b0; wq; scl = 1'b0; wq;
  endtask

  task automatic stopC;
    scl = 1'b0; sdaM = 1'b0; wq; scl = 1'b1; wq; sdaM = 1'b1; wq;
    chk(pullLow == 1'b0, "R2 release after stop", pullLow, 0);
  endtask

  task automatic clkBit(input logic b, output logic s);
    logic s2;
    sdaM = b; wq; scl = 1'b1; wq; s = sdaLine; wq; s2 = sdaLine;
    chk(s == s2, "R10 data stable while clock high", s2, s);
    scl = 1'b0; wq;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(v[i], s);
    clkBit(1'b1, s);
    ack = !s;
  endtask

  task automatic readByte(input bit hostAck, input bit reroll, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s);
      v[i] = s;
    end
    if (reroll) begin
      lockF = 1'($urandom); agcF = 1'($urandom); code = 3'($urandom);
    end
    clkBit(!hostAck, s);
  endtask

  task automatic doRead(input logic [1:0] addrSel, input int nBytes);
    bit ack, match;
    logic [7:0] v, e;
    match = (addrSel == sel);
    startC;
    sendByte({5'b11000, addrSel, 1'b1}, ack);
    chk(ack == match, match ? "R3 read address ack" : "R4 mismatch no ack", ack, match);
    if (match) begin
      for (int k = 0; k < nBytes; k++) begin
        e = expStatus(expPor, lockF, agcF, code);
        readByte(k != nBytes - 1, 1'b1, v);
        chk(v == e, k == 0 ? "R6 status byte" : "R7 repeated status byte", v, e);
      end
      expPor = 1'b0;
    end else begin
      readByte(1'b0, 1'b0, v);
      chk(v == 8'hFF, "R4 line released after mismatch", v, 8'hFF);
    end
    stopC;
  endtask

  task automatic doWrite(input logic [1:0] addrSel);
    bit ack, match;
    match = (addrSel == sel);
    startC;
    sendByte({5'b11000, addrSel, 1'b0}, ack);
    chk(ack == match, "R3 write address ack", ack, match);
    sendByte(8'($urandom), ack);
    chk(ack == 1'b0, "R5 write data not acknowledged", ack, 0);
    stopC;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic s;
    logic [7:0] v, e;
    bit ack;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    chk(pullLow == 1'b0, "R1 reset releases line", pullLow, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(pullLow == 1'b0, "R1 idle after reset", pullLow, 0);

    sel = 2'b10; lockF = 1'b1; agcF = 1'b0; code = 3'b101;
    doWrite(2'b10);                       // R5, R9
    doRead(2'b01, 1);                     // R4, R9
    // R2: abort address mid-byte with a repeated START
    startC;
    for (int i = 0; i < 4; i++) clkBit(1'b1, s);
    chk(pullLow == 1'b0, "R2 no drive mid-address", pullLow, 0);
    // R1, R9: POR still set; R7 three bytes with recapture
    doRead(2'b10, 3);
    // R8: later read shows cleared indicator
    lockF = 1'b0; agcF = 1'b1; code = 3'b010;
    startC;
    sendByte({5'b11000, 2'b10, 1'b1}, ack);
    chk(ack == 1'b1, "R3 read ack", ack, 1);
    e = expStatus(1'b0, lockF, agcF, code);
    readByte(1'b0, 1'b0, v);
    chk(v == e, "R8 indicator cleared after nack", v, e);
    chk(pullLow == 1'b0, "R8 released after nack", pullLow, 0);
    stopC;

    for (int t = 0; t < 18; t++) begin
      sel = 2'($urandom);
      lockF = 1'($urandom); agcF = 1'($urandom); code = 3'($urandom);
      if ($urandom % 3 == 0) doWrite(($urandom % 4 == 0) ? 2'($urandom) : sel);
      else doRead(($urandom % 4 == 0) ? 2'($urandom) : sel, 1 + int'($urandom % 3));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule